// File: doc/BRIEF.md
# Sampled Average Multilevel Modulator for One Converter Leg

This block turns a stream of normalized voltage reference samples into the number of half-bridge submodules to insert in the upper and lower arm of one leg of a modular multilevel converter. On every sample strobe it shifts the signed reference up by half the arm size N. This gives a value between 0 and N. The integer part is the lower of the two nearest levels. The fractional part is the duty of the next level up. A symmetric triangular carrier spanning one sampling interval is then compared against that duty.

Two operating modes are selectable. In plain mode both arms use the same pulse, so the inserted total stays at N and the leg output has N+1 distinct levels. In split mode the lower arm uses a pulse of the same length centred half an interval away from the upper one. The inserted total then moves among N-1, N and N+1 while still averaging N over the interval. This gives 2N+1 distinct output levels.

The timing core is a three-state sequencer: Idle, Rise and Fall. A strobe moves any state to Rise with the carrier at zero. Rise counts the carrier up and passes to Fall when the carrier reaches its top value. Fall counts down and passes to Idle when the carrier reaches zero. Idle holds the carrier at zero with both pulses off, so the arms sit at the lower nearest level until the next strobe.

Top module: `sam_leg_modulator`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, both arm counts are 0.
- R2: A strobe latches the sample. The biased reference is ref_in + N*128, where ref_in is two's complement with 8 fractional bits. The level L is the biased value shifted right by 8, and the duty f is its low 8 bits. The carrier is c = t for t = 0..255 and c = 511 - t for t = 256..511, where t counts clocks from the first cycle after the strobe edge.
- R3: With mode_sel = 0 (plain), define pu = 1 while f > c. Then upper = N - L - pu and lower = L + pu, so upper + lower = N in every cycle.
- R4: With mode_sel = 1 (split), upper = N - L - pu and lower = L + pl, where pl = 1 while c >= 256 - f. The sum stays within N-1..N+1, and summed over the 512 cycles it equals 512*N.
- R5: In split mode, sweeping the reference over its full range makes lower - upper + N take all 2N+1 values 0..2N. In plain mode it takes only the N+1 even values.
- R6: A biased reference below 0 gives L = 0 and f = 0. A biased reference at or above N*256 gives L = N and f = 0. Both counts always stay within 0..N.
- R7: A strobe that arrives before the 512 cycles are over restarts the carrier at 0 with the new sample, whatever the phase.
- R8: When 512 cycles pass without a strobe, the block sits in Idle with upper = N - L and lower = L.
- R9: An arm_n value above MAX_N (16) is treated as MAX_N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle pulse that latches a new sample and restarts the interval |
| mode_sel | input | 1 | 0 = plain (fixed total), 1 = split (2N+1 levels) |
| arm_n | input | 5 | Submodules per arm, N |
| ref_in | input | 16 | Signed reference, 8 fractional bits, nominal range -N/2..+N/2 |
| upper_cnt | output | 5 | Submodules inserted in the upper arm |
| lower_cnt | output | 5 | Submodules inserted in the lower arm |

## Verification
A carrier that is off by one step, or a phase transition taken a cycle early or late, moves the pulse edges. That shows up as a count mismatch in the very cycle the edge should have occurred. A wrong level or duty split shows up from the first cycle after the strobe, because the lower count equals L whenever no pulse is active. A wrong lower-pulse placement in split mode breaks the interval average of the sum or the set of visited levels. Both of these are checked at the end of every interval.

// File: rtl/sam_leg_pkg.sv
package sam_leg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RISE = 2'd1,
        PH_FALL = 2'd2
    } car_phase_t;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_SPLIT = 1'b1
    } mod_mode_t;
endpackage

// File: rtl/sam_ref_split.sv
module sam_ref_split #(
    parameter int MAX_N  = 16,
    parameter int REF_W  = 16,
    parameter int FRAC_W = 8,
    parameter int NW     = $clog2(MAX_N + 1)
) (
    input  logic signed [REF_W-1:0]  ref_val,
    input  logic        [NW-1:0]     n_val,
    output logic        [NW-1:0]     lvl,
    output logic        [FRAC_W-1:0] duty
);
    localparam int SW = REF_W + NW + FRAC_W;

    logic signed [SW-1:0] ref_ext;
    logic signed [SW-1:0] off;
    logic signed [SW-1:0] lim;
    logic signed [SW-1:0] biased;

    always_comb begin
        ref_ext = $signed({{(SW-REF_W){ref_val[REF_W-1]}}, ref_val});
        off     = $signed({{(SW-NW){1'b0}}, n_val}) <<< (FRAC_W - 1);
        lim     = $signed({{(SW-NW){1'b0}}, n_val}) <<< FRAC_W;
        biased  = ref_ext + off;
        if (biased < 0) begin
            lvl  = '0;
            duty = '0;
        end else if (biased >= lim) begin
            lvl  = n_val;
            duty = '0;
        end else begin
            lvl  = NW'(biased >>> FRAC_W);
            duty = biased[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/sam_tri_carrier.sv
module sam_tri_carrier
    import sam_leg_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [FRAC_W-1:0] car,
    output car_phase_t        phase
);
    localparam logic [FRAC_W-1:0] CAR_TOP = '1;

    car_phase_t        ph_d;
    logic [FRAC_W-1:0] car_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            car   <= '0;
        end else begin
            phase <= ph_d;
            car   <= car_d;
        end
    end

    always_comb begin
        ph_d  = phase;
        car_d = car;
        if (restart) begin
            ph_d  = PH_RISE;
            car_d = '0;
        end else begin
            unique case (phase)
                PH_IDLE: car_d = '0;
                PH_RISE: begin
                    if (car == CAR_TOP) ph_d = PH_FALL;
                    else                car_d = car + 1'b1;
                end
                PH_FALL: begin
                    if (car == '0) ph_d = PH_IDLE;
                    else           car_d = car - 1'b1;
                end
                default: begin
                    ph_d  = PH_IDLE;
                    car_d = '0;
                end
            endcase
        end
    end

    assert_rise_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RISE && !restart && car != CAR_TOP) |=> (phase == PH_RISE && car == $past(car) + 1'b1));
    assert_peak_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RISE && !restart && car == CAR_TOP) |=> (phase == PH_FALL && car == CAR_TOP));
    assert_fall_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FALL && !restart && car != '0) |=> (phase == PH_FALL && car == $past(car) - 1'b1));
    assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FALL && !restart && car == '0) |=> (phase == PH_IDLE));
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == PH_RISE && car == '0));
endmodule

// File: rtl/sam_arm_map.sv
module sam_arm_map
    import sam_leg_pkg::*;
#(
    parameter int MAX_N  = 16,
    parameter int FRAC_W = 8,
    parameter int NW     = $clog2(MAX_N + 1)
) (
    input  mod_mode_t         mode,
    input  logic              active,
    input  logic [NW-1:0]     n_val,
    input  logic [NW-1:0]     lvl,
    input  logic [FRAC_W-1:0] duty,
    input  logic [FRAC_W-1:0] car,
    output logic [NW-1:0]     up_cnt,
    output logic [NW-1:0]     lo_cnt
);
    localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    logic                 pu;
    logic                 pl;
    logic                 lo_pulse;
    logic [FRAC_W:0]      thr;
    logic signed [NW+1:0] ru;
    logic signed [NW+1:0] rl;

    function automatic logic [NW-1:0] fit(input logic signed [NW+1:0] v, input logic [NW-1:0] hi);
        if (v < 0)                          return '0;
        else if (v > $signed({2'b00, hi})) return hi;
        else                                return v[NW-1:0];
    endfunction

    always_comb begin
        thr      = FULL - {1'b0, duty};
        pu       = active && (duty > car);
        pl       = active && ({1'b0, car} >= thr);
        lo_pulse = (mode == MODE_SPLIT) ? pl : pu;
        ru       = $signed({2'b00, n_val}) - $signed({2'b00, lvl}) - $signed({{(NW+1){1'b0}}, pu});
        rl       = $signed({2'b00, lvl}) + $signed({{(NW+1){1'b0}}, lo_pulse});
        up_cnt   = fit(ru, n_val);
        lo_cnt   = fit(rl, n_val);
    end
endmodule

// File: rtl/sam_leg_modulator.sv
module sam_leg_modulator
    import sam_leg_pkg::*;
#(
    parameter int MAX_N  = 16,
    parameter int REF_W  = 16,
    parameter int FRAC_W = 8,
    parameter int NW     = $clog2(MAX_N + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_stb,
    input  logic                    mode_sel,
    input  logic        [NW-1:0]    arm_n,
    input  logic signed [REF_W-1:0] ref_in,
    output logic        [NW-1:0]    upper_cnt,
    output logic        [NW-1:0]    lower_cnt
);
    localparam logic [NW-1:0] N_CAP = NW'(MAX_N);

    logic [NW-1:0]     n_cap;
    logic [NW-1:0]     lvl_d;
    logic [FRAC_W-1:0] duty_d;
    logic [NW-1:0]     lvl_q;
    logic [FRAC_W-1:0] duty_q;
    logic [NW-1:0]     n_q;
    mod_mode_t         mode_q;
    logic [FRAC_W-1:0] car;
    car_phase_t        phase;

    assign n_cap = (arm_n > N_CAP) ? N_CAP : arm_n;

    sam_ref_split #(.MAX_N(MAX_N), .REF_W(REF_W), .FRAC_W(FRAC_W), .NW(NW)) u_split (
        .ref_val (ref_in),
        .n_val   (n_cap),
        .lvl     (lvl_d),
        .duty    (duty_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            duty_q <= '0;
            n_q    <= '0;
            mode_q <= MODE_PLAIN;
        end else if (sample_stb) begin
            lvl_q  <= lvl_d;
            duty_q <= duty_d;
            n_q    <= n_cap;
            mode_q <= mod_mode_t'(mode_sel);
        end
    end

    sam_tri_carrier #(.FRAC_W(FRAC_W)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sample_stb),
        .car     (car),
        .phase   (phase)
    );

    sam_arm_map #(.MAX_N(MAX_N), .FRAC_W(FRAC_W), .NW(NW)) u_map (
        .mode    (mode_q),
        .active  (phase != PH_IDLE),
        .n_val   (n_q),
        .lvl     (lvl_q),
        .duty    (duty_q),
        .car     (car),
        .up_cnt  (upper_cnt),
        .lo_cnt  (lower_cnt)
    );

    logic [NW:0] tot;
    assign tot = {1'b0, upper_cnt} + {1'b0, lower_cnt};

    assert_plain_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PLAIN) |-> (tot == {1'b0, n_q}));
    assert_split_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SPLIT) |-> (tot <= {1'b0, n_q} + 1'b1 && tot + 1'b1 >= {1'b0, n_q}));
    assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_cnt <= n_q && lower_cnt <= n_q));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (lower_cnt == lvl_q && upper_cnt == n_q - lvl_q));
    assert_n_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q <= N_CAP));
endmodule

// File: tb/sam_leg_modulator_test.sv
module sam_leg_modulator_test;
    localparam int MAX_N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic        mode_sel = 1'b0;
    logic [4:0]  arm_n = '0;
    logic signed [15:0] ref_in = '0;
    logic [4:0]  upper_cnt;
    logic [4:0]  lower_cnt;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [63:0] seen;

    always #2 clk = ~clk;

    sam_leg_modulator uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .mode_sel   (mode_sel),
        .arm_n      (arm_n),
        .ref_in     (ref_in),
        .upper_cnt  (upper_cnt),
        .lower_cnt  (lower_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Caller is positioned at a negedge; the strobe is driven here.
    task automatic run_sample(input int refv, input int n, input bit md, input int cycles, input string tag);
        int ne, nref, lv, f, c, pu, pl, eu, el, acc;
        string tg;
        ne = (n > MAX_N) ? MAX_N : n;
        nref = refv + ne * 128;
        if (nref < 0) begin lv = 0; f = 0; end
        else if (nref >= ne * 256) begin lv = ne; f = 0; end
        else begin lv = nref / 256; f = nref % 256; end
        ref_in = 16'(refv);
        arm_n = 5'(n);
        mode_sel = md;
        sample_stb = 1'b1;
        acc = 0;
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            if (t == 0) sample_stb = 1'b0;
            if (t >= 512) begin
                eu = ne - lv; el = lv; tg = "R8 idle";
            end else begin
                c  = (t < 256) ? t : 511 - t;
                pu = (f > c) ? 1 : 0;
                pl = (c >= 256 - f) ? 1 : 0;
                eu = ne - lv - pu;
                el = lv + (md ? pl : pu);
                tg = tag;
                acc += int'(upper_cnt) + int'(lower_cnt);
                seen[int'(lower_cnt) - int'(upper_cnt) + ne] = 1'b1;
            end
            checks++;
            if (upper_cnt !== 5'(eu) || lower_cnt !== 5'(el)) begin
                fails++;
                $display("FAIL %s: t=%0d upper/lower actual %0d/%0d expected %0d/%0d",
                         tg, t, upper_cnt, lower_cnt, eu, el);
            end
        end
        if (cycles >= 512)
            chk(acc == 512 * ne, md ? "R4 interval average of arm sum" : "R3 interval sum", acc, 512 * ne);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(upper_cnt == 0 && lower_cnt == 0, "R1 in reset", int'(upper_cnt) + int'(lower_cnt), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(upper_cnt == 0 && lower_cnt == 0, "R1 before first strobe", int'(upper_cnt) + int'(lower_cnt), 0);
        end
        // R2 split of reference into level and duty
        run_sample(0, 4, 1'b0, 512, "R2");
        run_sample(16'sh0180, 4, 1'b1, 512, "R2");
        // R3 plain mode, several patterns
        run_sample(-700, 6, 1'b0, 512, "R3");
        run_sample(37, 6, 1'b0, 512, "R3");
        run_sample(300, 6, 1'b0, 512, "R3");
        run_sample(755, 6, 1'b0, 512, "R3");
        // R4 split mode, several patterns
        run_sample(-300, 6, 1'b1, 512, "R4");
        run_sample(64, 6, 1'b1, 512, "R4");
        run_sample(200, 6, 1'b1, 512, "R4");
        run_sample(-100, 1, 1'b1, 512, "R4");
        run_sample(100, 1, 1'b1, 512, "R4");
        // R5 level coverage sweeps
        seen = '0;
        for (int k = -8; k <= 8; k++) run_sample(k * 64, 4, 1'b1, 512, "R5");
        chk(seen == 64'h1FF, "R5 split levels 0..2N", int'(seen[31:0]), 32'h1FF);
        seen = '0;
        for (int k = -8; k <= 8; k++) run_sample(k * 64, 4, 1'b0, 512, "R5");
        chk(seen == 64'h155, "R5 plain even levels only", int'(seen[31:0]), 32'h155);
        // R6 clamping at both ends and at the boundary
        run_sample(-3000, 4, 1'b1, 512, "R6");
        run_sample(3000, 4, 1'b1, 512, "R6");
        run_sample(511, 4, 1'b1, 512, "R6");
        run_sample(512, 4, 1'b0, 512, "R6");
        // R7 early restart during rise and during fall
        run_sample(200, 6, 1'b1, 100, "R7");
        run_sample(90, 5, 1'b0, 400, "R7");
        run_sample(-150, 6, 1'b1, 512, "R7");
        // R8 idle after interval without strobe, then a fresh sample
        run_sample(300, 6, 1'b1, 600, "R8");
        run_sample(-40, 3, 1'b1, 512, "R8");
        // R9 arm size above the maximum
        run_sample(100, 20, 1'b1, 512, "R9");
        run_sample(-1000, 31, 1'b0, 512, "R9");
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule